// File: doc/BRIEF.md
# Effective Address Calculation Unit

This block works out where an instruction operand lives. It takes a 3-bit addressing mode, a 3-bit register field, an operand size and a mask of permitted modes. From these it returns one of two results: a reference to a data or address register, or a full-width memory address. For the auto-increment and auto-decrement modes it also gives the new value for the address register. For every mode it reports how many bytes the program counter must advance past the extension words.

Modes that need extension words ask for them one at a time through a request/acknowledge handshake. The result appears as a one-cycle `done_o` pulse. The result outputs then keep their values until the next operation finishes. The register file contents, the program counter and the immediate pointer arrive on flat input buses. The caller must hold these buses stable from the start pulse until `done_o`.

Top module: `ea_calc_unit`

## Requirements
- R1: While reset is asserted and after it is released, `done_o`, `ext_req_o`, `illegal_o` and `wb_en_o` are 0.
- R2: Mode 0 gives a data register reference and mode 1 gives an address register reference. In both cases `is_reg_o`=1, `reg_ref_o` = {mode bit 0, register field}, no extension word is fetched and `pc_adv_o`=0.
- R3: Mode 2 uses address register An as the address. Mode 3 uses An as the address and writes back An+step. Mode 4 writes back An-step and also uses that value as the address. The step is 1, 2 or 4 for size 0 (byte), 1 (word) or 2 (long).
- R4: Mode 5 gives An plus the sign-extended 16-bit extension word, with `pc_adv_o`=2.
- R5: Mode 6 reads one extension word. Its fields are: bit 15 chooses the index register file (0 data, 1 address), bits 14..12 give the register number, bit 11 chooses a long index (1) or the sign-extended low 16 bits (0), and bits 7..0 hold a signed displacement. The address is An + displacement + index, with `pc_adv_o`=2.
- R6: Mode 7 with register field 0 sign-extends one extension word into the address (`pc_adv_o`=2). Register field 1 joins two words into the address, the first word fetched forming the upper half (`pc_adv_o`=4).
- R7: Mode 7 with register field 2 gives `pc_i` plus the sign-extended extension word, with `pc_adv_o`=2.
- R8: Mode 7 with register field 4 (immediate) gives `imm_ptr_i` plus 1 for a byte and `imm_ptr_i` for word or long. `pc_adv_o` is 2 for byte or word and 4 for long. No word is fetched.
- R9: Mask bit m (m = 0..6) permits mode m, and mask bit 7+r permits mode 7 with register field r (r = 0..4). A mode whose mask bit is clear is illegal. So are mode 7 with register field 3 or 5..7, and size code 3. An illegal result has `illegal_o`=1, `is_reg_o`=0, `wb_en_o`=0 and `pc_adv_o`=0, and fetches no word.
- R10: With no words to fetch, `done_o` pulses in the cycle after the accepting start. Otherwise `ext_req_o` rises in the cycle after start and stays high until the last word is acknowledged, and `done_o` pulses in the cycle after that acknowledge. A start raised while an operation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| mode_i | input | 3 | Addressing mode |
| reg_i | input | 3 | Register field |
| size_i | input | 2 | Operand size: 0 byte, 1 word, 2 long |
| legal_i | input | 12 | Permitted-mode mask |
| areg_i | input | 256 | Address registers 0..7, register k at bits 32k+31..32k |
| dreg_i | input | 256 | Data registers 0..7, same packing |
| pc_i | input | 32 | Program counter base for PC-relative mode |
| imm_ptr_i | input | 32 | Current extension pointer for immediates |
| ext_req_o | output | 1 | Extension word wanted |
| ext_ack_i | input | 1 | Extension word present on `ext_word_i` |
| ext_word_i | input | 16 | Extension word |
| done_o | output | 1 | One-cycle result pulse |
| illegal_o | output | 1 | Mode not permitted or not supported |
| is_reg_o | output | 1 | Result is a register reference |
| reg_ref_o | output | 4 | Register reference: bit 3 set for address register |
| addr_o | output | 32 | Memory address |
| wb_en_o | output | 1 | Address register update valid |
| wb_reg_o | output | 3 | Address register to update |
| wb_val_o | output | 32 | New address register value |
| pc_adv_o | output | 3 | Bytes of extension stream consumed |

## Verification
If the word counter were wrong, `ext_req_o` would stay high one acknowledge too long or drop one too early. The `done_o` pulse would then move by a cycle, and that shows up on the very next clock. If the high word were held wrongly, or the index field were decoded wrongly, the address would be wrong in the `done_o` cycle itself. The same holds for a step size or a mask bit index that is off by one. Because of this, every operation is checked cycle by cycle against the request line, the done pulse and the full result.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int EXT_W    = 16;
  localparam int NUM_REGS = 8;
  localparam int REG_W    = 3;
  localparam int MODE_W   = 3;
  localparam int SIZE_W   = 2;
  localparam int MASK_W   = 12;
  localparam int ADV_W    = 3;
  localparam int EXT_BASE = 7;   // mask bit of mode 7, register field 0

  typedef enum logic [3:0] {
    K_DREG, K_AREG, K_IND, K_POST, K_PRE, K_DISP, K_IDX,
    K_ABSW, K_ABSL, K_PCD, K_PCX, K_IMM, K_BAD
  } ea_kind_e;
endpackage

// File: rtl/ea_decode.sv
module ea_decode
  import ea_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic [REG_W-1:0]  rsel,
  input  logic [SIZE_W-1:0] size,
  input  logic [MASK_W-1:0] legal,
  output ea_kind_e          kind,
  output logic              illegal,
  output logic [1:0]        nwords,
  output logic [2:0]        step
);
  logic permit;

  always_comb begin
    kind = K_BAD;
    if (mode != 3'd7) begin
      kind = ea_kind_e'({1'b0, mode});
    end else begin
      case (rsel)
        3'd0:    kind = K_ABSW;
        3'd1:    kind = K_ABSL;
        3'd2:    kind = K_PCD;
        3'd3:    kind = K_PCX;
        3'd4:    kind = K_IMM;
        default: kind = K_BAD;
      endcase
    end
  end

  always_comb begin
    if (mode != 3'd7)   permit = legal[mode];
    else if (rsel <= 3'd4) permit = legal[EXT_BASE + int'(rsel)];
    else                permit = 1'b0;
  end

  assign illegal = !permit || (kind == K_PCX) || (kind == K_BAD) || (size == 2'd3);

  always_comb begin
    nwords = 2'd0;
    if (!illegal) begin
      case (kind)
        K_DISP, K_IDX, K_ABSW, K_PCD: nwords = 2'd1;
        K_ABSL:                       nwords = 2'd2;
        default:                      nwords = 2'd0;
      endcase
    end
  end

  always_comb begin
    case (size)
      2'd0:    step = 3'd1;
      2'd1:    step = 3'd2;
      default: step = 3'd4;
    endcase
  end
endmodule

// File: rtl/ea_fetch.sv
module ea_fetch
  import ea_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [1:0]       nwords,
  input  logic             ext_ack,
  input  logic [EXT_W-1:0] ext_word,
  output logic             busy,
  output logic             last,
  output logic [EXT_W-1:0] hi_word
);
  logic             busy_q, busy_d;
  logic [1:0]       cnt_q, cnt_d;
  logic [EXT_W-1:0] hi_q, hi_d;
  logic             take;

  assign take = busy_q && ext_ack;
  assign last = take && (cnt_q == 2'd1);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    hi_d   = hi_q;
    if (load) begin
      busy_d = 1'b1;
      cnt_d  = nwords;
    end else if (take) begin
      hi_d  = ext_word;
      cnt_d = cnt_q - 2'd1;
      if (cnt_q == 2'd1) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= 2'd0;
      hi_q   <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      if (take) hi_q <= hi_d;
    end
  end

  assign busy    = busy_q;
  assign hi_word = hi_q;

  assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !ext_ack |=> busy_q);
  assert_req_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !busy_q);
endmodule

// File: rtl/ea_addr_gen.sv
module ea_addr_gen
  import ea_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  ea_kind_e                    kind,
  input  logic [REG_W-1:0]            rsel,
  input  logic [SIZE_W-1:0]           size,
  input  logic [2:0]                  step,
  input  logic [NUM_REGS*DATA_W-1:0]  areg,
  input  logic [NUM_REGS*DATA_W-1:0]  dreg,
  input  logic [DATA_W-1:0]           pc,
  input  logic [DATA_W-1:0]           imm_ptr,
  input  logic [EXT_W-1:0]            hi_word,
  input  logic [EXT_W-1:0]            lo_word,
  output logic                        is_reg,
  output logic [REG_W:0]              reg_ref,
  output logic [DATA_W-1:0]           addr,
  output logic                        wb_en,
  output logic [DATA_W-1:0]           wb_val,
  output logic [ADV_W-1:0]            pc_adv
);
  localparam int PAIR_W = 2 * EXT_W;

  function automatic logic [DATA_W-1:0] sx16(input logic [EXT_W-1:0] v);
    return {{(DATA_W-EXT_W){v[EXT_W-1]}}, v};
  endfunction

  function automatic logic [DATA_W-1:0] sx8(input logic [7:0] v);
    return {{(DATA_W-8){v[7]}}, v};
  endfunction

  logic [DATA_W-1:0] base, xval, index, stepx;
  logic [REG_W-1:0]  xnum;
  logic [PAIR_W-1:0] pair;

  assign base  = areg[int'(rsel)*DATA_W +: DATA_W];
  assign xnum  = lo_word[14:12];
  assign xval  = lo_word[15] ? areg[int'(xnum)*DATA_W +: DATA_W]
                             : dreg[int'(xnum)*DATA_W +: DATA_W];
  assign index = lo_word[11] ? xval : sx16(xval[EXT_W-1:0]);
  assign stepx = DATA_W'(step);
  assign pair  = {hi_word, lo_word};

  always_comb begin
    is_reg  = 1'b0;
    reg_ref = '0;
    addr    = '0;
    wb_en   = 1'b0;
    wb_val  = '0;
    pc_adv  = '0;
    case (kind)
      K_DREG: begin is_reg = 1'b1; reg_ref = {1'b0, rsel}; end
      K_AREG: begin is_reg = 1'b1; reg_ref = {1'b1, rsel}; end
      K_IND:  addr = base;
      K_POST: begin addr = base; wb_en = 1'b1; wb_val = base + stepx; end
      K_PRE:  begin addr = base - stepx; wb_en = 1'b1; wb_val = base - stepx; end
      K_DISP: begin addr = base + sx16(lo_word); pc_adv = 3'd2; end
      K_IDX:  begin addr = base + sx8(lo_word[7:0]) + index; pc_adv = 3'd2; end
      K_ABSW: begin addr = sx16(lo_word); pc_adv = 3'd2; end
      K_ABSL: begin addr = DATA_W'(pair); pc_adv = 3'd4; end
      K_PCD:  begin addr = pc + sx16(lo_word); pc_adv = 3'd2; end
      K_IMM: begin
        addr   = imm_ptr + ((size == 2'd0) ? DATA_W'(1) : DATA_W'(0));
        pc_adv = (size == 2'd2) ? 3'd4 : 3'd2;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ea_calc_unit.sv
module ea_calc_unit
  import ea_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic [2:0]                 mode_i,
  input  logic [2:0]                 reg_i,
  input  logic [1:0]                 size_i,
  input  logic [11:0]                legal_i,
  input  logic [8*DATA_W-1:0]        areg_i,
  input  logic [8*DATA_W-1:0]        dreg_i,
  input  logic [DATA_W-1:0]          pc_i,
  input  logic [DATA_W-1:0]          imm_ptr_i,
  output logic                       ext_req_o,
  input  logic                       ext_ack_i,
  input  logic [15:0]                ext_word_i,
  output logic                       done_o,
  output logic                       illegal_o,
  output logic                       is_reg_o,
  output logic [3:0]                 reg_ref_o,
  output logic [DATA_W-1:0]          addr_o,
  output logic                       wb_en_o,
  output logic [2:0]                 wb_reg_o,
  output logic [DATA_W-1:0]          wb_val_o,
  output logic [2:0]                 pc_adv_o
);
  logic              busy, last, accept, finish;
  logic [EXT_W-1:0]  hi_word;
  logic [MODE_W-1:0] mode_q, cur_mode;
  logic [REG_W-1:0]  reg_q, cur_reg;
  logic [SIZE_W-1:0] size_q, cur_size;
  logic [MASK_W-1:0] legal_q, cur_legal;

  ea_kind_e          kind;
  logic              dec_illegal;
  logic [1:0]        dec_nwords;
  logic [2:0]        dec_step;

  logic              g_is_reg, g_wb_en;
  logic [REG_W:0]    g_ref;
  logic [DATA_W-1:0] g_addr, g_wb_val;
  logic [ADV_W-1:0]  g_adv;

  logic              done_d, ill_d, isreg_d, wb_en_d;
  logic [REG_W:0]    ref_d;
  logic [DATA_W-1:0] addr_d, wbv_d;
  logic [REG_W-1:0]  wbr_d;
  logic [ADV_W-1:0]  adv_d;

  assign accept    = start_i && !busy;
  assign cur_mode  = busy ? mode_q  : mode_i;
  assign cur_reg   = busy ? reg_q   : reg_i;
  assign cur_size  = busy ? size_q  : size_i;
  assign cur_legal = busy ? legal_q : legal_i;

  ea_decode u_dec (
    .mode(cur_mode), .rsel(cur_reg), .size(cur_size), .legal(cur_legal),
    .kind(kind), .illegal(dec_illegal), .nwords(dec_nwords), .step(dec_step)
  );

  ea_fetch u_fetch (
    .clk(clk), .rst_n(rst_n), .load(accept && (dec_nwords != 2'd0)),
    .nwords(dec_nwords), .ext_ack(ext_ack_i), .ext_word(ext_word_i),
    .busy(busy), .last(last), .hi_word(hi_word)
  );

  ea_addr_gen #(.DATA_W(DATA_W)) u_gen (
    .kind(kind), .rsel(cur_reg), .size(cur_size), .step(dec_step),
    .areg(areg_i), .dreg(dreg_i), .pc(pc_i), .imm_ptr(imm_ptr_i),
    .hi_word(hi_word), .lo_word(ext_word_i),
    .is_reg(g_is_reg), .reg_ref(g_ref), .addr(g_addr),
    .wb_en(g_wb_en), .wb_val(g_wb_val), .pc_adv(g_adv)
  );

  assign finish = (accept && (dec_nwords == 2'd0)) || last;

  always_comb begin
    done_d  = finish;
    ill_d   = illegal_o;
    isreg_d = is_reg_o;
    ref_d   = reg_ref_o;
    addr_d  = addr_o;
    wb_en_d = wb_en_o;
    wbr_d   = wb_reg_o;
    wbv_d   = wb_val_o;
    adv_d   = pc_adv_o;
    if (finish) begin
      ill_d   = dec_illegal;
      isreg_d = g_is_reg && !dec_illegal;
      ref_d   = dec_illegal ? '0 : g_ref;
      addr_d  = dec_illegal ? '0 : g_addr;
      wb_en_d = g_wb_en && !dec_illegal;
      wbr_d   = cur_reg;
      wbv_d   = dec_illegal ? '0 : g_wb_val;
      adv_d   = dec_illegal ? '0 : g_adv;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      reg_q   <= '0;
      size_q  <= '0;
      legal_q <= '0;
    end else if (accept) begin
      mode_q  <= mode_i;
      reg_q   <= reg_i;
      size_q  <= size_i;
      legal_q <= legal_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
      is_reg_o  <= 1'b0;
      reg_ref_o <= '0;
      addr_o    <= '0;
      wb_en_o   <= 1'b0;
      wb_reg_o  <= '0;
      wb_val_o  <= '0;
      pc_adv_o  <= '0;
    end else begin
      done_o    <= done_d;
      illegal_o <= ill_d;
      is_reg_o  <= isreg_d;
      reg_ref_o <= ref_d;
      addr_o    <= addr_d;
      wb_en_o   <= wb_en_d;
      wb_reg_o  <= wbr_d;
      wb_val_o  <= wbv_d;
      pc_adv_o  <= adv_d;
    end
  end

  assign ext_req_o = busy;

  assert_illegal_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && illegal_o |-> !wb_en_o && !is_reg_o && (pc_adv_o == 3'd0));
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !ext_req_o);
  assert_fetch_begins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (dec_nwords != 2'd0) |=> ext_req_o && !done_o);
  assert_regref_plain_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && is_reg_o |-> !wb_en_o && (pc_adv_o == 3'd0));
endmodule

// File: tb/tb_ea_calc_unit.sv
module tb_ea_calc_unit;
  logic clk = 1'b0;
  logic rst_n;
  logic start_i, ext_ack_i;
  logic [2:0] mode_i, reg_i;
  logic [1:0] size_i;
  logic [11:0] legal_i;
  logic [255:0] areg_i, dreg_i;
  logic [31:0] pc_i, imm_ptr_i;
  logic [15:0] ext_word_i;
  logic ext_req_o, done_o, illegal_o, is_reg_o, wb_en_o;
  logic [3:0] reg_ref_o;
  logic [31:0] addr_o, wb_val_o;
  logic [2:0] wb_reg_o, pc_adv_o;

  logic [31:0] A [8];
  logic [31:0] D [8];
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  always_comb begin
    for (int i = 0; i < 8; i++) begin
      areg_i[32*i +: 32] = A[i];
      dreg_i[32*i +: 32] = D[i];
    end
  end

  ea_calc_unit dut (.*);

  // expected values from the reference model
  bit e_ill, e_isreg, e_wb;
  logic [3:0] e_ref;
  logic [31:0] e_addr, e_wbval;
  int e_adv, e_nw;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] s16(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  task automatic ref_calc(input int md, input int rg, input int sz, input logic [11:0] lg,
                          input logic [15:0] w0, input logic [15:0] w1);
    int step;
    bit ok;
    logic [31:0] x;
    step = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    if (sz == 3) ok = 0;
    else if (md < 7) ok = lg[md];
    else ok = (rg <= 4) && (rg != 3) && lg[7 + rg];
    e_ill = !ok; e_isreg = 0; e_wb = 0; e_ref = 0; e_addr = 0; e_wbval = 0; e_adv = 0; e_nw = 0;
    if (!ok) return;
    case (md)
      0: begin e_isreg = 1; e_ref = 4'(rg); end
      1: begin e_isreg = 1; e_ref = 4'(rg + 8); end
      2: e_addr = A[rg];
      3: begin e_addr = A[rg]; e_wb = 1; e_wbval = A[rg] + step; end
      4: begin e_addr = A[rg] - step; e_wb = 1; e_wbval = A[rg] - step; end
      5: begin e_addr = A[rg] + s16(w0); e_nw = 1; e_adv = 2; end
      6: begin
        x = w0[15] ? A[w0[14:12]] : D[w0[14:12]];
        if (!w0[11]) x = s16(x[15:0]);
        e_addr = A[rg] + {{24{w0[7]}}, w0[7:0]} + x; e_nw = 1; e_adv = 2;
      end
      default: case (rg)
        0: begin e_addr = s16(w0); e_nw = 1; e_adv = 2; end
        1: begin e_addr = {w0, w1}; e_nw = 2; e_adv = 4; end
        2: begin e_addr = pc_i + s16(w0); e_nw = 1; e_adv = 2; end
        default: begin e_addr = imm_ptr_i + ((sz == 0) ? 1 : 0); e_adv = (sz == 2) ? 4 : 2; end
      endcase
    endcase
  endtask

  task automatic run_op(input string tag, input int md, input int rg, input int sz,
                        input logic [11:0] lg, input logic [15:0] w0, input logic [15:0] w1,
                        input int dly, input bit noise);
    ref_calc(md, rg, sz, lg, w0, w1);
    @(negedge clk);
    start_i = 1; mode_i = 3'(md); reg_i = 3'(rg); size_i = 2'(sz); legal_i = lg;
    @(negedge clk);
    start_i = noise && (e_nw > 0);
    if (noise) mode_i = 3'd0;
    for (int k = 0; k < e_nw; k++) begin
      for (int d = 0; d < dly; d++) begin
        chk({tag, " R10 request held"}, 32'(ext_req_o), 1);
        chk({tag, " R10 no early done"}, 32'(done_o), 0);
        @(negedge clk);
      end
      chk({tag, " R10 request"}, 32'(ext_req_o), 1);
      chk({tag, " R10 no early done"}, 32'(done_o), 0);
      ext_ack_i = 1; ext_word_i = (k == 0) ? w0 : w1;
      @(negedge clk);
      ext_ack_i = 0; ext_word_i = 16'hDEAD;
    end
    start_i = 0;
    chk({tag, " R10 done pulse"}, 32'(done_o), 1);
    chk({tag, " R10 request low"}, 32'(ext_req_o), 0);
    chk({tag, " R9 illegal"}, 32'(illegal_o), 32'(e_ill));
    chk({tag, " R2 is_reg"}, 32'(is_reg_o), 32'(e_isreg));
    if (e_isreg) chk({tag, " R2 reg_ref"}, 32'(reg_ref_o), 32'(e_ref));
    else if (!e_ill) chk({tag, " address"}, addr_o, e_addr);
    chk({tag, " R3 wb_en"}, 32'(wb_en_o), 32'(e_wb));
    if (e_wb) begin
      chk({tag, " R3 wb_reg"}, 32'(wb_reg_o), 32'(rg));
      chk({tag, " R3 wb_val"}, wb_val_o, e_wbval);
    end
    chk({tag, " pc_adv"}, 32'(pc_adv_o), 32'(e_adv));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      A[i] = 32'h1000_0000 + 32'(i) * 32'h110;
      D[i] = 32'h0000_0040 + 32'(i);
    end
    A[2] = 32'h8000_0100;
    D[3] = 32'h1234_FFF0;
    pc_i = 32'h0000_4000; imm_ptr_i = 32'h0000_2000;
    rst_n = 0; start_i = 0; ext_ack_i = 0; ext_word_i = 0;
    mode_i = 0; reg_i = 0; size_i = 0; legal_i = 12'hFFF;
    repeat (3) @(negedge clk);
    chk("R1 done in reset", 32'(done_o), 0);
    chk("R1 request in reset", 32'(ext_req_o), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 done after reset", 32'(done_o), 0);
    chk("R1 illegal after reset", 32'(illegal_o), 0);
    chk("R1 wb_en after reset", 32'(wb_en_o), 0);

    run_op("R2 data reg", 0, 3, 2, 12'hFFF, 0, 0, 0, 0);
    run_op("R2 addr reg", 1, 5, 1, 12'hFFF, 0, 0, 0, 0);
    run_op("R3 indirect", 2, 2, 2, 12'hFFF, 0, 0, 0, 0);
    run_op("R3 postinc byte", 3, 4, 0, 12'hFFF, 0, 0, 0, 0);
    run_op("R3 postinc word", 3, 4, 1, 12'hFFF, 0, 0, 0, 0);
    run_op("R3 postinc long", 3, 4, 2, 12'hFFF, 0, 0, 0, 0);
    run_op("R3 predec long", 4, 1, 2, 12'hFFF, 0, 0, 0, 0);
    run_op("R3 predec byte", 4, 7, 0, 12'hFFF, 0, 0, 0, 0);
    run_op("R4 disp negative", 5, 6, 1, 12'hFFF, 16'hFFF0, 0, 0, 0);
    run_op("R4 disp positive", 5, 2, 1, 12'hFFF, 16'h1234, 0, 2, 0);
    run_op("R5 word data index", 6, 1, 1, 12'hFFF, 16'h3080, 0, 0, 0);
    run_op("R5 long addr index", 6, 0, 2, 12'hFFF, 16'hA87F, 0, 1, 0);
    run_op("R6 abs short", 7, 0, 1, 12'hFFF, 16'h8000, 0, 0, 0);
    run_op("R6 abs long", 7, 1, 2, 12'hFFF, 16'h00AB, 16'hCDEF, 3, 0);
    run_op("R7 pc relative", 7, 2, 1, 12'hFFF, 16'hFF00, 0, 0, 0);
    run_op("R8 imm byte", 7, 4, 0, 12'hFFF, 0, 0, 0, 0);
    run_op("R8 imm word", 7, 4, 1, 12'hFFF, 0, 0, 0, 0);
    run_op("R8 imm long", 7, 4, 2, 12'hFFF, 0, 0, 0, 0);
    run_op("R9 mask clear postinc", 3, 4, 1, 12'hFF7, 0, 0, 0, 0);
    run_op("R9 mask clear abs long", 7, 1, 2, 12'hEFF, 0, 0, 0, 0);
    run_op("R9 pc index", 7, 3, 1, 12'hFFF, 0, 0, 0, 0);
    run_op("R9 mode7 reg6", 7, 6, 1, 12'hFFF, 0, 0, 0, 0);
    run_op("R9 size code 3", 2, 2, 3, 12'hFFF, 0, 0, 0, 0);
    run_op("R10 start while busy", 7, 1, 2, 12'hFFF, 16'h1357, 16'h9BDF, 2, 1);
    run_op("R10 after busy start", 5, 3, 1, 12'hFFF, 16'h0010, 0, 0, 0);
    @(negedge clk);
    chk("R10 done single pulse", 32'(done_o), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule